// File: doc/BRIEF.md
# 32-bit SECDED Check-Bit Codec

This block protects 32-bit words held in a storage array. It corrects any single flipped bit and detects any double flip. It has two independent paths. The encode path is purely combinational. It turns a data word into a 7-bit check field that is written alongside the data.

The check path takes a word and its check field as read back from storage, recomputes the check field and XORs it with the stored one to form a syndrome. It then classifies the syndrome into one of four named outcomes:
- CLEAN: the syndrome is zero.
- DATA_FIX: the syndrome matches the coverage column of one data bit.
- CHECK_FIX: the syndrome has exactly one bit set.
- UNCORR: any other non-zero syndrome.

A DATA_FIX outcome flips the matching data bit. The outcome selects the single-error and double-error flags. An output stage, registered by default, presents the corrected word, both flags and a valid strobe.

The coverage matrix is fixed and irregular rather than positional. Every data bit owns a distinct 3-bit column. So every single error produces an odd-weight syndrome, and every double error produces a non-zero, even-weight syndrome that can never be confused with a correctable one.

Top module: `secded32_codec`

## Requirements
- R1: Check bit k of `enc_check_o` (bit 0 at the least significant position) is the XOR of the data bits selected by mask k. The masks are k0=0x111A555B, k1=0x22509A6D, k2=0x4464E38E, k3=0x878703F0, k4=0xF807FC00, k5=0xFFF80000 and k6=0x08A92CB7.
- R2: A word read back with the check field that R1 gives for it is delivered unchanged, with both flags low (CLEAN).
- R3: A word with exactly one flipped data bit is delivered with that bit restored and `dec_single_o` high (DATA_FIX).
- R4: A word whose check field alone has one flipped bit is delivered with its data unchanged and `dec_single_o` high (CHECK_FIX).
- R5: Any two flipped bits among the 39 stored bits raise `dec_double_o` with `dec_single_o` low, and the data is passed through exactly as received (UNCORR).
- R6: `dec_single_o` and `dec_double_o` are never high together.
- R7: In a cycle whose output valid is low, both flags are low, whatever data was presented.
- R8: With the default registered output, results appear exactly one clock after their inputs, and `dec_valid_o` repeats `dec_valid_i` from one cycle earlier. After reset, valid, flags and data are all zero.
- R9: The encode path has no clock latency: `enc_check_o` follows `enc_data_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 32 | Word to be encoded |
| enc_check_o | output | 7 | Check field for `enc_data_i` |
| dec_valid_i | input | 1 | Read-back word is present |
| dec_data_i | input | 32 | Stored data as read back |
| dec_check_i | input | 7 | Stored check field as read back |
| dec_valid_o | output | 1 | Decoded result is present |
| dec_data_o | output | 32 | Corrected (or passed-through) data |
| dec_single_o | output | 1 | A single error was found and handled |
| dec_double_o | output | 1 | An uncorrectable double error was found |

## Verification
The hardest outcome to reach from the ports is a flip that lands on a check bit. Storage never produces it by itself, and it must not be mistaken for a data-bit fix. The bench encodes a known word through the block's own encode path and rebuilds the check field from the masks as well. It then inverts each of the seven check bits in turn, and every data bit, and then pairs of data/data, data/check and check/check bits. Each injected word is fed through the check path and the four outcomes are compared at the registered outputs.

// File: rtl/secded32_pkg.sv
package secded32_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;

    // Parity coverage: entry k selects the data bits folded into check bit k.
    localparam logic [CHK_W-1:0][DATA_W-1:0] COVER = {
        32'h08A92CB7,   // k6
        32'hFFF80000,   // k5
        32'hF807FC00,   // k4
        32'h878703F0,   // k3
        32'h4464E38E,   // k2
        32'h22509A6D,   // k1
        32'h111A555B    // k0
    };

    typedef enum logic [1:0] {
        SYN_CLEAN     = 2'd0,
        SYN_DATA_FIX  = 2'd1,
        SYN_CHECK_FIX = 2'd2,
        SYN_UNCORR    = 2'd3
    } syn_class_e;

    // Syndrome produced by a flip of data bit idx.
    function automatic logic [CHK_W-1:0] column(input int unsigned idx);
        logic [CHK_W-1:0] col;
        for (int k = 0; k < CHK_W; k++) begin
            col[k] = COVER[k][idx];
        end
        return col;
    endfunction

endpackage

// File: rtl/secded32_encoder.sv
module secded32_encoder
    import secded32_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        assign chk_o[k] = ^(data_i & COVER[k]);
    end
endmodule

// File: rtl/secded32_check.sv
module secded32_check
    import secded32_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] fixed_o,
    output syn_class_e        cls_o
);
    logic [CHK_W-1:0]  recomputed;
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] hit;

    secded32_encoder u_recalc (
        .data_i (data_i),
        .chk_o  (recomputed)
    );

    assign syndrome = recomputed ^ chk_i;

    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        assign hit[i] = (syndrome == column(i));
    end

    assign fixed_o = data_i ^ hit;

    always_comb begin
        if (syndrome == '0) begin
            cls_o = SYN_CLEAN;
        end else if (|hit) begin
            cls_o = SYN_DATA_FIX;
        end else if ($onehot(syndrome)) begin
            cls_o = SYN_CHECK_FIX;
        end else begin
            cls_o = SYN_UNCORR;
        end
    end
endmodule

// File: rtl/secded32_outstage.sv
module secded32_outstage
    import secded32_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  syn_class_e        cls_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    logic single_n;
    logic double_n;

    always_comb begin
        single_n = 1'b0;
        double_n = 1'b0;
        unique case (cls_i)
            SYN_CLEAN:     ;
            SYN_DATA_FIX:  single_n = valid_i;
            SYN_CHECK_FIX: single_n = valid_i;
            SYN_UNCORR:    double_n = valid_i;
            default:       ;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_o  <= 1'b0;
                data_o   <= '0;
                single_o <= 1'b0;
                double_o <= 1'b0;
            end else begin
                valid_o  <= valid_i;
                data_o   <= data_i;
                single_o <= single_n;
                double_o <= double_n;
            end
        end
    end else begin : g_comb
        assign valid_o  = valid_i;
        assign data_o   = data_i;
        assign single_o = single_n;
        assign double_o = double_n;
    end
endmodule

// File: rtl/secded32_codec.sv
module secded32_codec
    import secded32_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] enc_data_i,
    output logic [6:0]  enc_check_o,
    input  logic        dec_valid_i,
    input  logic [31:0] dec_data_i,
    input  logic [6:0]  dec_check_i,
    output logic        dec_valid_o,
    output logic [31:0] dec_data_o,
    output logic        dec_single_o,
    output logic        dec_double_o
);
    logic [DATA_W-1:0] fixed;
    syn_class_e        cls;

    secded32_encoder u_enc (
        .data_i (enc_data_i),
        .chk_o  (enc_check_o)
    );

    secded32_check u_chk (
        .data_i  (dec_data_i),
        .chk_i   (dec_check_i),
        .fixed_o (fixed),
        .cls_o   (cls)
    );

    secded32_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (dec_valid_i),
        .data_i   (fixed),
        .cls_i    (cls),
        .valid_o  (dec_valid_o),
        .data_o   (dec_data_o),
        .single_o (dec_single_o),
        .double_o (dec_double_o)
    );
endmodule

// File: rtl/secded32_codec_chk.sv
module secded32_codec_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dec_valid_i,
    input logic [31:0] dec_data_i,
    input logic        dec_valid_o,
    input logic [31:0] dec_data_o,
    input logic        dec_single_o,
    input logic        dec_double_o
);
    if (REG_OUT) begin : g_seq
        a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(dec_single_o && dec_double_o));

        a_r7_idle_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_valid_o |-> (!dec_single_o && !dec_double_o));

        a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i |=> dec_valid_o);

        a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_valid_i |=> !dec_valid_o);

        a_r5_double_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i ##1 dec_double_o |-> dec_data_o == $past(dec_data_i));

        a_r3_single_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i ##1 dec_single_o |-> $countones(dec_data_o ^ $past(dec_data_i)) <= 1);

        a_r2_clean_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid_i ##1 (dec_valid_o && !dec_single_o && !dec_double_o)
                |-> dec_data_o == $past(dec_data_i));
    end else begin : g_imm
        always_comb begin
            if (rst_n) begin
                a_r6_flags_exclusive_c: assert (!(dec_single_o && dec_double_o));
                a_r7_idle_no_flags_c: assert (dec_valid_o || (!dec_single_o && !dec_double_o));
            end
        end
    end
endmodule

bind secded32_codec secded32_codec_chk #(.REG_OUT(REG_OUT)) u_codec_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid_i  (dec_valid_i),
    .dec_data_i   (dec_data_i),
    .dec_valid_o  (dec_valid_o),
    .dec_data_o   (dec_data_o),
    .dec_single_o (dec_single_o),
    .dec_double_o (dec_double_o)
);

// File: tb/tb_secded32_codec.sv
`timescale 1ns/1ps
module tb_secded32_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [6:0]  enc_check_o;
    logic        dec_valid_i = 1'b0;
    logic [31:0] dec_data_i = '0;
    logic [6:0]  dec_check_i = '0;
    logic        dec_valid_o;
    logic [31:0] dec_data_o;
    logic        dec_single_o;
    logic        dec_double_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    secded32_codec dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data_i),
        .enc_check_o  (enc_check_o),
        .dec_valid_i  (dec_valid_i),
        .dec_data_i   (dec_data_i),
        .dec_check_i  (dec_check_i),
        .dec_valid_o  (dec_valid_o),
        .dec_data_o   (dec_data_o),
        .dec_single_o (dec_single_o),
        .dec_double_o (dec_double_o)
    );

    // Masks taken from R1
    function automatic logic [6:0] ref_check(input logic [31:0] d);
        logic [31:0] m [7];
        logic [6:0]  c;
        m[0] = 32'h111A555B; m[1] = 32'h22509A6D; m[2] = 32'h4464E38E;
        m[3] = 32'h878703F0; m[4] = 32'hF807FC00; m[5] = 32'hFFF80000;
        m[6] = 32'h08A92CB7;
        for (int k = 0; k < 7; k++) c[k] = ^(d & m[k]);
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one read-back word, then compare the registered result one clock later.
    task automatic decode_one(input string req, input logic [31:0] d, input logic [6:0] c,
                              input logic [31:0] exp_d, input logic exp_s, input logic exp_x);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_data_i  = d;
        dec_check_i = c;
        @(negedge clk);
        check(req, {29'd0, dec_valid_o, dec_single_o, dec_double_o}, {29'd0, 1'b1, exp_s, exp_x});
        check(req, {32'd0, dec_data_o}, {32'd0, exp_d});
        dec_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R8 reset", {29'd0, dec_valid_o, dec_single_o, dec_double_o}, 64'd0);
        check("R8 reset data", {32'd0, dec_data_o}, 64'd0);
    endtask

    task automatic t_encode;
        logic [31:0] pats [6];
        pats[0] = 32'h0; pats[1] = 32'hFFFFFFFF; pats[2] = 32'hA5A5A5A5;
        pats[3] = 32'h12345678; pats[4] = 32'h80000001; pats[5] = 32'h0F0F00F0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            enc_data_i = pats[i];
            #1;
            check("R1 R9 encode", {57'd0, enc_check_o}, {57'd0, ref_check(pats[i])});
        end
        for (int b = 0; b < 32; b++) begin
            enc_data_i = 32'd1 << b;
            #1;
            check("R1 walking one", {57'd0, enc_check_o}, {57'd0, ref_check(32'd1 << b)});
        end
    endtask

    task automatic t_clean;
        decode_one("R2 clean zero", 32'h0, ref_check(32'h0), 32'h0, 1'b0, 1'b0);
        decode_one("R2 clean ones", 32'hFFFFFFFF, ref_check(32'hFFFFFFFF), 32'hFFFFFFFF, 1'b0, 1'b0);
        enc_data_i = 32'hDEADBEEF;
        #1;
        decode_one("R2 clean via encoder", 32'hDEADBEEF, enc_check_o, 32'hDEADBEEF, 1'b0, 1'b0);
    endtask

    task automatic t_data_flip;
        logic [31:0] w;
        w = 32'h3C5A9617;
        for (int b = 0; b < 32; b++) begin
            decode_one("R3 data flip", w ^ (32'd1 << b), ref_check(w), w, 1'b1, 1'b0);
        end
    endtask

    task automatic t_check_flip;
        logic [31:0] w;
        w = 32'hC001D00D;
        for (int k = 0; k < 7; k++) begin
            decode_one("R4 check flip", w, ref_check(w) ^ (7'd1 << k), w, 1'b1, 1'b0);
        end
    endtask

    task automatic t_double;
        logic [31:0] w;
        logic [31:0] bad;
        w = 32'h5EED1234;
        for (int b = 0; b < 31; b++) begin
            bad = w ^ (32'd1 << b) ^ (32'd1 << (b + 1));
            decode_one("R5 data-data", bad, ref_check(w), bad, 1'b0, 1'b1);
        end
        bad = w ^ 32'h80000001;
        decode_one("R5 far data pair", bad, ref_check(w), bad, 1'b0, 1'b1);
        for (int k = 0; k < 7; k++) begin
            bad = w ^ (32'd1 << (k * 4));
            decode_one("R5 data-check", bad, ref_check(w) ^ (7'd1 << k), bad, 1'b0, 1'b1);
        end
        for (int k = 0; k < 6; k++) begin
            decode_one("R5 check-check", w, ref_check(w) ^ (7'd3 << k), w, 1'b0, 1'b1);
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        dec_valid_i = 1'b0;
        dec_data_i  = 32'h00000003;
        dec_check_i = ref_check(32'h0);
        @(negedge clk);
        check("R7 idle double", {61'd0, dec_valid_o, dec_single_o, dec_double_o}, 64'd0);
        dec_data_i = 32'h00000001;
        @(negedge clk);
        check("R7 idle single", {61'd0, dec_valid_o, dec_single_o, dec_double_o}, 64'd0);
    endtask

    task automatic t_stream;
        logic [31:0] w;
        logic [31:0] prev;
        prev = '0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            w = 32'h01020304 * (i + 1);
            if (i > 0) begin
                check("R8 latency data", {32'd0, dec_data_o}, {32'd0, prev});
                check("R8 latency valid", {63'd0, dec_valid_o}, 64'd1);
            end
            dec_valid_i = 1'b1;
            dec_data_i  = w ^ 32'h00000100;
            dec_check_i = ref_check(w);
            prev = w;
            @(negedge clk);
        end
        check("R8 last data", {32'd0, dec_data_o}, {32'd0, prev});
        check("R6 last flags", {62'd0, dec_single_o, dec_double_o}, {62'd0, 2'b10});
        dec_valid_i = 1'b0;
        @(negedge clk);
        check("R8 valid drops", {63'd0, dec_valid_o}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_encode();
        t_clean();
        t_data_flip();
        t_check_flip();
        t_double();
        t_idle();
        t_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule